// File: doc/BRIEF.md
# Memory Access Attribute Resolver

The resolver takes one memory request per cycle and decides the attributes under which it is carried out. These are a 2-bit cache mode, a precise flag and a write-protect flag. It also reports which source supplied them. Each request brings the upper bits of its address (the page tag), the bus it travels on (instruction or data), its class (special or normal), the requester's privilege, a test-and-set marker and a write marker.

Nine region descriptors are held at the inputs, all in the same form:

| Index | Descriptor |
|---|---|
| 0 | MMU register window |
| 1, 2 | Local RAM windows 0 and 1 |
| 3, 4 | Local ROM windows 0 and 1 |
| 5, 6 | Guard regions 0 and 1 (data bus) |
| 7, 8 | Guard regions 2 and 3 (instruction bus) |

The lowest-index enabled descriptor that matches wins. Which descriptors are enabled depends on the bus and the class of the request.

When nothing matches, the default attributes apply. If the MMU and virtual mode are both on, the request is instead flagged for translation. The result is registered and appears one cycle after the request strobe. A write that resolves to write-protected memory raises a fault flag alongside its attributes.

Top module: `mem_attr_resolver`

## Requirements
- R1: A special-class request always resolves to cache mode 2'b10 (non-cacheable), precise=1, write-protect=0, fault=0 and translate=0. When no local window is allowed to match, its source is 11 (forced).
- R2: A special-class request with `req_iack`=1 may match local RAM/ROM windows (sources 1..4) only while `iack_mask`=0. With `iack_mask`=1, or with `req_iack`=0, its source is 11. Its attributes stay as in R1 in every case.
- R3: For a normal data-bus request, the winner is the first match in this order: RAM0(1), RAM1(2), ROM0(3), ROM1(4), guard 0(5), guard 1(6). If none matches, the default (9) applies. Guard regions 2 and 3 are never considered.
- R4: For a normal instruction-bus request, the order is RAM0(1), RAM1(2), ROM0(3), ROM1(4), guard 2(7), guard 3(8), then the default (9). Guard regions 0 and 1 and the MMU window are never considered.
- R5: The MMU window (source 0) ranks above RAM0 for a normal data-bus request, but only when `mmu_en`=1 and `req_super`=1.
- R6: A normal data-bus test-and-set request whose winner is neither RAM0 nor RAM1 gets cache mode 2'b10 and precise=1. Its write-protect value is taken from the winner unchanged.
- R7: A normal request that matches no descriptor gets source 10, translate=1 and zero attributes when `mmu_en`=1 and `virt_en`=1. Otherwise it gets source 9 with the default attributes.
- R8: Descriptor i matches only when its valid bit is 1 and ((`req_page` XOR base_i) AND mask_i) is zero. The winner supplies its own 2-bit cache mode, precise bit and write-protect bit.
- R9: `rsp_fault` is 1 exactly when the request is a normal-class write and its resolved write-protect is 1.
- R10: The response appears on the clock edge that samples `req_valid`=1, with `rsp_valid`=1. After a cycle with `req_valid`=0, `rsp_valid` is 0 and every other response output keeps its value.
- R11: While reset is asserted (active low), every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_page | input | TAG_W | Upper address bits of the request |
| req_ibus | input | 1 | 1 = instruction bus, 0 = data bus |
| req_special | input | 1 | 1 = special-class access |
| req_iack | input | 1 | Special access is an interrupt acknowledge or emulator operation |
| req_super | input | 1 | Privileged requester |
| req_tas | input | 1 | Test-and-set access |
| req_write | input | 1 | Write access |
| mmu_en | input | 1 | MMU present and enabled |
| virt_en | input | 1 | Virtual mode enabled |
| iack_mask | input | 1 | Suppress local-window matches for interrupt/emulator accesses |
| win_valid | input | 9 | Per-descriptor valid bits |
| win_base | input | 9*TAG_W | Per-descriptor base tags, descriptor i at [i*TAG_W +: TAG_W] |
| win_mask | input | 9*TAG_W | Per-descriptor compare masks |
| win_cmode | input | 18 | Per-descriptor cache modes, descriptor i at [2i +: 2] |
| win_precise | input | 9 | Per-descriptor precise bits |
| win_wprot | input | 9 | Per-descriptor write-protect bits |
| dflt_cmode | input | 2 | Default cache mode |
| dflt_precise | input | 1 | Default precise bit |
| dflt_wprot | input | 1 | Default write-protect bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_src | output | 4 | Winning source code (0..11) |
| rsp_cmode | output | 2 | Resolved cache mode |
| rsp_precise | output | 1 | Resolved precise flag |
| rsp_wprot | output | 1 | Resolved write-protect flag |
| rsp_xlate | output | 1 | Request needs translation |
| rsp_fault | output | 1 | Write to protected memory |

## Verification
The hardest situation to bring about is a request that is matched by several descriptors at once. Only then does the priority order show, and it must differ between the two buses. Random descriptors with uniform masks almost never overlap.

The stimulus therefore draws masks as the AND of two random words. This leaves few compared bits, so many descriptors hit the same page at the same time. It also steers half of the request pages onto the base of a random descriptor. Directed cases complete the coverage: all descriptors open at once, then switched off one by one on each bus; the interrupt mask toggled; and test-and-set inside and outside the RAM windows.

// File: rtl/mar_pkg.sv
package mar_pkg;

    localparam int NUM_WIN = 9;
    localparam int SRC_W   = 4;
    localparam int CM_W    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_MMUWIN = 4'd0,
        SRC_RAM0   = 4'd1,
        SRC_RAM1   = 4'd2,
        SRC_ROM0   = 4'd3,
        SRC_ROM1   = 4'd4,
        SRC_GRD0   = 4'd5,
        SRC_GRD1   = 4'd6,
        SRC_GRD2   = 4'd7,
        SRC_GRD3   = 4'd8,
        SRC_DFLT   = 4'd9,
        SRC_VIRT   = 4'd10,
        SRC_FORCED = 4'd11
    } src_e;

    localparam logic [CM_W-1:0] CM_NC = 2'b10;

    typedef struct packed {
        logic            valid;
        src_e            src;
        logic [CM_W-1:0] cmode;
        logic            precise;
        logic            wprot;
        logic            xlate;
        logic            fault;
    } rsp_t;

endpackage

// File: rtl/mar_win_match.sv
module mar_win_match #(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] page,
    input  logic             valid,
    input  logic [TAG_W-1:0] base,
    input  logic [TAG_W-1:0] mask,
    output logic             hit
);

    logic [TAG_W-1:0] diff;

    always_comb begin
        diff = (page ^ base) & mask;
        hit  = valid && (diff == '0);
    end

endmodule

// File: rtl/mar_prio_pick.sv
module mar_prio_pick #(
    parameter int N     = 9,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |cand;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mem_attr_resolver.sv
module mem_attr_resolver
    import mar_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [TAG_W-1:0]         req_page,
    input  logic                     req_ibus,
    input  logic                     req_special,
    input  logic                     req_iack,
    input  logic                     req_super,
    input  logic                     req_tas,
    input  logic                     req_write,
    input  logic                     mmu_en,
    input  logic                     virt_en,
    input  logic                     iack_mask,
    input  logic [NUM_WIN-1:0]       win_valid,
    input  logic [NUM_WIN*TAG_W-1:0] win_base,
    input  logic [NUM_WIN*TAG_W-1:0] win_mask,
    input  logic [NUM_WIN*CM_W-1:0]  win_cmode,
    input  logic [NUM_WIN-1:0]       win_precise,
    input  logic [NUM_WIN-1:0]       win_wprot,
    input  logic [CM_W-1:0]          dflt_cmode,
    input  logic                     dflt_precise,
    input  logic                     dflt_wprot,
    output logic                     rsp_valid,
    output logic [SRC_W-1:0]         rsp_src,
    output logic [CM_W-1:0]          rsp_cmode,
    output logic                     rsp_precise,
    output logic                     rsp_wprot,
    output logic                     rsp_xlate,
    output logic                     rsp_fault
);

    // Enable sets per request kind; bit i enables descriptor i.
    localparam logic [NUM_WIN-1:0] EN_LOCAL = 9'b0_0001_1110;
    localparam logic [NUM_WIN-1:0] EN_IBUS  = 9'b1_1001_1110;
    localparam logic [NUM_WIN-1:0] EN_DBUS  = 9'b0_0111_1110;

    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN-1:0] en_vec;
    logic [NUM_WIN-1:0] cand;
    logic               pick_any;
    logic [SRC_W-1:0]   pick_idx;
    logic [CM_W-1:0]    cm_a [NUM_WIN];
    logic               tas_force;
    src_e               pick_src;

    rsp_t rsp_d, rsp_q;

    // One comparator per descriptor
    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            mar_win_match #(.TAG_W(TAG_W)) u_match (
                .page  (req_page),
                .valid (win_valid[gi]),
                .base  (win_base[gi*TAG_W +: TAG_W]),
                .mask  (win_mask[gi*TAG_W +: TAG_W]),
                .hit   (win_hit[gi])
            );
            assign cm_a[gi] = win_cmode[gi*CM_W +: CM_W];
        end
    endgenerate

    // Which descriptors may take part in this request
    always_comb begin
        en_vec = '0;
        if (req_special) begin
            if (req_iack && !iack_mask) en_vec = EN_LOCAL;
        end else if (req_ibus) begin
            en_vec = EN_IBUS;
        end else begin
            en_vec = EN_DBUS | {{(NUM_WIN-1){1'b0}}, (mmu_en & req_super)};
        end
    end

    assign cand = win_hit & en_vec;

    // Descriptor index order equals priority order on both buses
    mar_prio_pick #(.N(NUM_WIN), .IDX_W(SRC_W)) u_pick (
        .cand (cand),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    assign pick_src  = src_e'(pick_idx);
    assign tas_force = req_tas && !req_ibus &&
                       !(pick_any && (pick_src == SRC_RAM0 || pick_src == SRC_RAM1));

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.xlate = 1'b0;
            rsp_d.fault = 1'b0;
            if (req_special) begin
                rsp_d.src     = pick_any ? pick_src : SRC_FORCED;
                rsp_d.cmode   = CM_NC;
                rsp_d.precise = 1'b1;
                rsp_d.wprot   = 1'b0;
            end else begin
                if (pick_any) begin
                    rsp_d.src     = pick_src;
                    rsp_d.cmode   = cm_a[pick_idx];
                    rsp_d.precise = win_precise[pick_idx];
                    rsp_d.wprot   = win_wprot[pick_idx];
                end else if (mmu_en && virt_en) begin
                    rsp_d.src     = SRC_VIRT;
                    rsp_d.cmode   = '0;
                    rsp_d.precise = 1'b0;
                    rsp_d.wprot   = 1'b0;
                    rsp_d.xlate   = 1'b1;
                end else begin
                    rsp_d.src     = SRC_DFLT;
                    rsp_d.cmode   = dflt_cmode;
                    rsp_d.precise = dflt_precise;
                    rsp_d.wprot   = dflt_wprot;
                end
                if (tas_force) begin
                    rsp_d.cmode   = CM_NC;
                    rsp_d.precise = 1'b1;
                end
                rsp_d.fault = req_write & rsp_d.wprot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_src     = rsp_q.src;
    assign rsp_cmode   = rsp_q.cmode;
    assign rsp_precise = rsp_q.precise;
    assign rsp_wprot   = rsp_q.wprot;
    assign rsp_xlate   = rsp_q.xlate;
    assign rsp_fault   = rsp_q.fault;

endmodule

// File: rtl/mem_attr_resolver_chk.sv
module mem_attr_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_special,
    input logic       req_ibus,
    input logic       iack_mask,
    input logic       rsp_valid,
    input logic [3:0] rsp_src,
    input logic [1:0] rsp_cmode,
    input logic       rsp_precise,
    input logic       rsp_wprot,
    input logic       rsp_xlate,
    input logic       rsp_fault
);

    // R1
    special_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_special |=> rsp_cmode == 2'b10 && rsp_precise && !rsp_wprot && !rsp_fault && !rsp_xlate);

    // R2
    iack_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_special && iack_mask |=> rsp_src == 4'd11);

    // R4
    ibus_no_mmuwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_special && req_ibus |=> rsp_src != 4'd0 && rsp_src != 4'd5 && rsp_src != 4'd6);

    // R7
    xlate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_xlate |-> rsp_src == 4'd10 && !rsp_wprot);

    // R9
    fault_needs_wprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_wprot);

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(rsp_src) && $stable(rsp_cmode) && $stable(rsp_fault));

endmodule

bind mem_attr_resolver mem_attr_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_special (req_special),
    .req_ibus    (req_ibus),
    .iack_mask   (iack_mask),
    .rsp_valid   (rsp_valid),
    .rsp_src     (rsp_src),
    .rsp_cmode   (rsp_cmode),
    .rsp_precise (rsp_precise),
    .rsp_wprot   (rsp_wprot),
    .rsp_xlate   (rsp_xlate),
    .rsp_fault   (rsp_fault)
);

// File: tb/tb_mem_attr_resolver.sv
`timescale 1ns/1ps
module tb_mem_attr_resolver;

    localparam int TW = 8;
    localparam int NW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid, req_ibus, req_special, req_iack, req_super, req_tas, req_write;
    logic [TW-1:0] req_page;
    logic          mmu_en, virt_en, iack_mask;
    logic [1:0]    dflt_cmode;
    logic          dflt_precise, dflt_wprot;

    logic          b_valid [NW];
    logic [TW-1:0] b_base  [NW];
    logic [TW-1:0] b_mask  [NW];
    logic [1:0]    b_cm    [NW];
    logic          b_pr    [NW];
    logic          b_wp    [NW];

    logic [NW-1:0]    win_valid, win_precise, win_wprot;
    logic [NW*TW-1:0] win_base, win_mask;
    logic [NW*2-1:0]  win_cmode;

    genvar gi;
    generate
        for (gi = 0; gi < NW; gi++) begin : g_pack
            assign win_valid[gi]          = b_valid[gi];
            assign win_base[gi*TW +: TW]  = b_base[gi];
            assign win_mask[gi*TW +: TW]  = b_mask[gi];
            assign win_cmode[gi*2 +: 2]   = b_cm[gi];
            assign win_precise[gi]        = b_pr[gi];
            assign win_wprot[gi]          = b_wp[gi];
        end
    endgenerate

    logic       rsp_valid, rsp_precise, rsp_wprot, rsp_xlate, rsp_fault;
    logic [3:0] rsp_src;
    logic [1:0] rsp_cmode;

    mem_attr_resolver #(.TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
        .req_ibus(req_ibus), .req_special(req_special), .req_iack(req_iack),
        .req_super(req_super), .req_tas(req_tas), .req_write(req_write),
        .mmu_en(mmu_en), .virt_en(virt_en), .iack_mask(iack_mask),
        .win_valid(win_valid), .win_base(win_base), .win_mask(win_mask),
        .win_cmode(win_cmode), .win_precise(win_precise), .win_wprot(win_wprot),
        .dflt_cmode(dflt_cmode), .dflt_precise(dflt_precise), .dflt_wprot(dflt_wprot),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_cmode(rsp_cmode),
        .rsp_precise(rsp_precise), .rsp_wprot(rsp_wprot), .rsp_xlate(rsp_xlate),
        .rsp_fault(rsp_fault)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [10:0] actual();
        return {rsp_valid, rsp_src, rsp_cmode, rsp_precise, rsp_wprot, rsp_xlate, rsp_fault};
    endfunction

    function automatic bit hits(int k);
        return b_valid[k] && (((req_page ^ b_base[k]) & b_mask[k]) == '0);
    endfunction

    // Reference: {valid, src, cmode, precise, wprot, xlate, fault}
    function automatic logic [10:0] model();
        int order [7];
        int n = 0;
        int win = -1;
        logic [3:0] src;
        logic [1:0] cm;
        logic pr, wp, xl;
        if (req_special) begin
            if (req_iack && !iack_mask)
                for (int k = 1; k <= 4; k++) if (win < 0 && hits(k)) win = k;
            src = (win >= 0) ? 4'(win) : 4'd11;
            return {1'b1, src, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0};
        end
        if (req_ibus) begin
            order[0]=1; order[1]=2; order[2]=3; order[3]=4; order[4]=7; order[5]=8; n = 6;
        end else begin
            if (mmu_en && req_super) begin order[n] = 0; n++; end
            for (int k = 1; k <= 6; k++) begin order[n] = k; n++; end
        end
        for (int j = 0; j < n; j++) if (win < 0 && hits(order[j])) win = order[j];
        xl = 1'b0;
        if (win >= 0) begin
            src = 4'(win); cm = b_cm[win]; pr = b_pr[win]; wp = b_wp[win];
        end else if (mmu_en && virt_en) begin
            src = 4'd10; cm = 2'b00; pr = 1'b0; wp = 1'b0; xl = 1'b1;
        end else begin
            src = 4'd9; cm = dflt_cmode; pr = dflt_precise; wp = dflt_wprot;
        end
        if (!req_ibus && req_tas && win != 1 && win != 2) begin
            cm = 2'b10; pr = 1'b1;
        end
        return {1'b1, src, cm, pr, wp, xl, req_write & wp};
    endfunction

    task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_page = '0; req_ibus = 0; req_special = 0; req_iack = 0;
        req_super = 0; req_tas = 0; req_write = 0;
    endtask

    task automatic set_win(int k, bit v, logic [TW-1:0] base, logic [TW-1:0] mask,
                           logic [1:0] cm, bit pr, bit wp);
        b_valid[k] = v; b_base[k] = base; b_mask[k] = mask;
        b_cm[k] = cm; b_pr[k] = pr; b_wp[k] = wp;
    endtask

    // Drive at negedge, response registered at next posedge, sample at following negedge
    task automatic issue(string tag);
        logic [10:0] exp;
        req_valid = 1'b1;
        exp = model();
        @(negedge clk);
        check(tag, actual(), exp);
        req_valid = 1'b0;
    endtask

    task automatic rand_config();
        for (int k = 0; k < NW; k++)
            set_win(k, ($urandom % 3) != 0, TW'($urandom), TW'($urandom & $urandom),
                    2'($urandom), 1'($urandom), 1'($urandom));
        mmu_en = 1'($urandom); virt_en = 1'($urandom); iack_mask = 1'($urandom);
        dflt_cmode = 2'($urandom); dflt_precise = 1'($urandom); dflt_wprot = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [10:0] held;
        void'($urandom(32'd1234));
        idle_inputs();
        mmu_en = 0; virt_en = 0; iack_mask = 0;
        dflt_cmode = 2'b01; dflt_precise = 0; dflt_wprot = 1;
        for (int k = 0; k < NW; k++) set_win(k, 0, 8'h00, 8'h00, 2'b00, 0, 0);
        repeat (3) @(negedge clk);
        check("R11 reset state", actual(), 11'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 default path and R9 fault on protected default
        req_write = 1; issue("R7 default attributes / R9 fault");
        mmu_en = 1; virt_en = 1; req_write = 1; issue("R7 virtual hand-off");
        mmu_en = 0; virt_en = 0; req_write = 0;

        // All descriptors open: priority walk
        for (int k = 0; k < NW; k++) set_win(k, 1, 8'h00, 8'h00, 2'(k), k[0], k[1]);
        mmu_en = 1; req_super = 1; issue("R5 MMU window on top for data");
        req_super = 0; issue("R5 MMU window needs privilege");
        req_super = 1; req_ibus = 1; issue("R4 MMU window ignored on instruction bus");
        req_ibus = 0; mmu_en = 0;
        for (int k = 0; k <= 4; k++) b_valid[k] = 0;
        req_write = 1; issue("R3 data picks guard 0 / R9");
        req_ibus = 1; issue("R4 instruction picks guard 2");
        b_valid[5] = 0; b_valid[7] = 0;
        req_ibus = 0; issue("R3 data picks guard 1");
        req_ibus = 1; issue("R4 instruction picks guard 3");
        req_ibus = 0; req_write = 0;

        // R8 mask compare and valid gating
        for (int k = 0; k < NW; k++) b_valid[k] = 0;
        set_win(1, 1, 8'hA0, 8'hF0, 2'b01, 0, 1);
        req_page = 8'hA7; issue("R8 masked-out bits ignored");
        req_page = 8'hB0; issue("R8 compared bit differs");
        b_valid[1] = 0; req_page = 8'hA0; issue("R8 invalid window never matches");

        // R1/R2 special class
        for (int k = 0; k < NW; k++) set_win(k, 1, 8'h00, 8'h00, 2'b01, 0, 1);
        req_special = 1; req_iack = 1; iack_mask = 0; req_write = 1;
        issue("R2 iack hits RAM0 with mask clear");
        iack_mask = 1; issue("R2 iack suppressed with mask set");
        iack_mask = 0; req_iack = 0; issue("R1 special forced attributes");
        req_special = 0; req_write = 0;

        // R6 test-and-set
        for (int k = 0; k <= 4; k++) b_valid[k] = 0;
        req_tas = 1; req_write = 1; issue("R6 tas outside RAM forced, wprot kept");
        b_valid[2] = 1; b_cm[2] = 2'b00; b_pr[2] = 0; issue("R6 tas inside RAM1 keeps window");
        req_tas = 0; req_write = 0;

        // R10 hold when idle
        req_page = 8'h55; req_valid = 1; @(negedge clk);
        held = actual();
        req_valid = 0; req_page = 8'h00; req_special = 1; @(negedge clk);
        check("R10 idle cycle holds outputs", actual(), {1'b0, held[9:0]});
        req_special = 0;

        // Constrained random
        for (int it = 0; it < 3000; it++) begin
            if (it % 40 == 0) rand_config();
            req_ibus    = 1'($urandom);
            req_special = ($urandom % 6) == 0;
            req_iack    = 1'($urandom);
            req_super   = 1'($urandom);
            req_tas     = ($urandom % 4) == 0;
            req_write   = 1'($urandom);
            req_page    = ($urandom % 2) ? b_base[$urandom % NW] : TW'($urandom);
            issue("R3/R4/R8 random request");
            if ($urandom % 8 == 0) @(negedge clk);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule